// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one general-purpose I/O port of 32 pins sitting behind a plain memory-mapped register interface with a 32-bit data bus. Reads return data in the same cycle. Writes take effect at the next clock edge. Software sets a driven value and an output enable for each pin, and can read back the pad inputs after synchronization.

Each pin can raise an interrupt. A 2-bit trigger field per pin selects one of four conditions: low level, high level, rising edge or falling edge. Detected events collect in a sticky status register, which software clears by writing ones to it. A mask register decides which pending flags reach the interrupt outputs.

The outputs are split so that the two halves of the port can be serviced separately. One line covers pins 0 to 15, another covers pins 16 to 31, and a third combines both. Software handles both-edge behaviour by swapping a pin between the two level modes, so the block itself has no both-edge mode.

Top module: `gpiot_port`

## Requirements
- R1: After reset, the output data, direction, both trigger-configuration and mask registers read zero, and all three interrupt outputs are low.
- R2: `pad_out` always equals the output data register at byte offset 0x00, and `pad_oe` always equals the direction register at offset 0x04 (1 = drive the pin). Both registers read back what was written.
- R3: A read at offset 0x08 returns `pad_in` after a two-flop synchronizer. A write to 0x08 changes nothing.
- R4: Pin n takes its trigger field from bits [2*(n mod 16)+1 : 2*(n mod 16)]. Pins 0–15 use the low configuration register at 0x0C, and pins 16–31 use the high configuration register at 0x10. Both registers read back what was written.
- R5: With field value 2'b10 (rising), a pin's status bit sets when its synchronized input goes from 0 to 1, and does not set when it goes from 1 to 0.
- R6: With field value 2'b11 (falling), a pin's status bit sets when its synchronized input goes from 1 to 0, and does not set when it goes from 0 to 1.
- R7: With field value 2'b00 (low level) or 2'b01 (high level), a pin's status bit sets on every cycle that its synchronized input is 0 or 1 respectively.
- R8: Writing the status register at offset 0x18 clears each bit written as 1 and leaves each bit written as 0 unchanged. A status bit never rises without a trigger event.
- R9: When a trigger event and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: Status bits are recorded whatever the mask holds. Setting a mask bit for a pin that is already pending raises the interrupt at once.
- R11: `irq_lo` is high when any of pins 0–15 has both its status bit and its mask bit (offset 0x14, 1 = enabled) set. `irq_hi` does the same for pins 16–31.
- R12: `irq_any` is the OR of `irq_lo` and `irq_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read, zero when no read is selected |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Masked pending interrupt, pins 0–15 |
| irq_hi | output | 1 | Masked pending interrupt, pins 16–31 |
| irq_any | output | 1 | Either half pending |

## Verification
The bench builds the port with its defaults: 16 pins per half (a 32-bit port) and a two-stage synchronizer. These values put a pin in each configuration register and each interrupt half within reach. They also fix the settling delay that the bench waits after a pad change. With this build the bench drives edges on a low-half pin and a high-half pin, holds level conditions against write-one-to-clear to show that the set wins, and steps the mask across pins that are already pending so that each half output is checked separately.

// File: rtl/gpiot_pkg.sv
// Shared definitions for the GPIO interrupt port: register byte offsets and
// the per-pin trigger-field encoding. The encoding is decoded by the trigger
// detector and written by software, so its values are fixed.
package gpiot_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

    localparam int unsigned OFS_DATA   = 32'h00;
    localparam int unsigned OFS_DIR    = 32'h04;
    localparam int unsigned OFS_PAD    = 32'h08;
    localparam int unsigned OFS_CFG_LO = 32'h0C;
    localparam int unsigned OFS_CFG_HI = 32'h10;
    localparam int unsigned OFS_MASK   = 32'h14;
    localparam int unsigned OFS_STAT   = 32'h18;

endpackage

// File: rtl/gpiot_sync.sv
// Multi-flop synchronizer for the asynchronous pad inputs.
// Assumes: STAGES >= 2; each bit is synchronized on its own (bits are
// independent pins, so no bus coherence is needed). Reset clears all stages.
module gpiot_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpiot_trig.sv
// Per-pin trigger detection. Decodes each pin's 2-bit mode from the low or
// high configuration word and produces a one-cycle (edge) or continuous
// (level) hit. Assumes: sync_in is already synchronous to clk.
module gpiot_trig
    import gpiot_pkg::*;
#(
    parameter int unsigned HALF  = 16,
    localparam int unsigned N     = 2 * HALF,
    localparam int unsigned CFG_W = 2 * HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     sync_in,
    input  logic [CFG_W-1:0] cfg_lo,
    input  logic [CFG_W-1:0] cfg_hi,
    output logic [N-1:0]     hit
);

    logic [N-1:0] prev_q;

    // Remember last cycle's synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar p = 0; p < N; p++) begin : g_pin
        trig_mode_e mode_w;

        if (p < HALF) begin : g_lo
            assign mode_w = trig_mode_e'(cfg_lo[2*p +: 2]);
        end else begin : g_hi
            assign mode_w = trig_mode_e'(cfg_hi[2*(p-HALF) +: 2]);
        end

        assign hit[p] = (mode_w == TRIG_LOW)  ? !sync_in[p] :
                        (mode_w == TRIG_HIGH) ?  sync_in[p] :
                        (mode_w == TRIG_RISE) ? ( sync_in[p] && !prev_q[p]) :
                                                (!sync_in[p] &&  prev_q[p]);

        // R5: a rising-mode hit only follows a 0 -> 1 step of the input
        assert_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w == TRIG_RISE && hit[p]) |-> (sync_in[p] && !$past(sync_in[p])));

        // R6: a falling-mode hit only follows a 1 -> 0 step of the input
        assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_w == TRIG_FALL && hit[p]) |-> (!sync_in[p] && $past(sync_in[p])));
    end

endmodule

// File: rtl/gpiot_status.sv
// Sticky interrupt status with write-one-to-clear, plus mask gating into
// the low-half and high-half interrupt lines. Assumes: clr is already
// qualified by a status-register write; a hit in the same cycle wins.
module gpiot_status #(
    parameter int unsigned HALF = 16,
    localparam int unsigned N   = 2 * HALF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status_q,
    output logic         irq_lo,
    output logic         irq_hi
);

    // Capture trigger hits; clear written ones unless a hit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | hit;
    end

    // Reduce the enabled pending flags of each half to its output.
    always_comb begin
        irq_lo = |(status_q[HALF-1:0] & mask[HALF-1:0]);
        irq_hi = |(status_q[N-1:HALF] & mask[N-1:HALF]);
    end

    // R8: a cleared bit without a concurrent hit is zero afterwards
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~hit)) |=> ((status_q & $past(clr & ~hit)) == '0));

    // R8: no status bit rises without a hit
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

    // R9: every hit is recorded, even against a clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

    // R11: a fully masked port never raises a half output
    assert_mask_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!irq_lo && !irq_hi));

endmodule

// File: rtl/gpiot_port.sv
// GPIO port top: register file, read multiplexer, pad drive, and the
// wiring of synchronizer, trigger detector and interrupt status.
// Assumes: single-cycle bus, byte offsets on bus_addr, reads combinational,
// writes registered; reset is synchronous and active low.
module gpiot_port
    import gpiot_pkg::*;
#(
    parameter int unsigned HALF_PINS   = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 5,
    localparam int unsigned NPINS      = 2 * HALF_PINS,
    localparam int unsigned CFG_W      = 2 * HALF_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);

    logic [NPINS-1:0] data_q, dir_q, mask_q;
    logic [CFG_W-1:0] cfg_lo_q, cfg_hi_q;
    logic [NPINS-1:0] pad_sync, hit, clr, status;
    logic             wr_en;

    assign wr_en = bus_sel && bus_wr;

    // Registered writes to the software-owned registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA):   data_q   <= bus_wdata;
                ADDR_W'(OFS_DIR):    dir_q    <= bus_wdata;
                ADDR_W'(OFS_CFG_LO): cfg_lo_q <= bus_wdata[CFG_W-1:0];
                ADDR_W'(OFS_CFG_HI): cfg_hi_q <= bus_wdata[CFG_W-1:0];
                ADDR_W'(OFS_MASK):   mask_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear vector for the status register.
    always_comb begin
        clr = '0;
        if (wr_en && bus_addr == ADDR_W'(OFS_STAT)) clr = bus_wdata;
    end

    // Same-cycle read multiplexer; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA):   bus_rdata = data_q;
                ADDR_W'(OFS_DIR):    bus_rdata = dir_q;
                ADDR_W'(OFS_PAD):    bus_rdata = pad_sync;
                ADDR_W'(OFS_CFG_LO): bus_rdata = NPINS'(cfg_lo_q);
                ADDR_W'(OFS_CFG_HI): bus_rdata = NPINS'(cfg_hi_q);
                ADDR_W'(OFS_MASK):   bus_rdata = mask_q;
                ADDR_W'(OFS_STAT):   bus_rdata = status;
                default:             bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign irq_any = irq_lo || irq_hi;

    gpiot_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    gpiot_trig #(.HALF(HALF_PINS)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (pad_sync),
        .cfg_lo  (cfg_lo_q),
        .cfg_hi  (cfg_hi_q),
        .hit     (hit)
    );

    gpiot_status #(.HALF(HALF_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clr      (clr),
        .mask     (mask_q),
        .status_q (status),
        .irq_lo   (irq_lo),
        .irq_hi   (irq_hi)
    );

    // R12: the combined line needs at least one enabled pin
    assert_any_needs_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (mask_q != '0));

    // R12: the combined line follows a raised half line
    assert_any_covers_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo || irq_hi) |-> irq_any);

endmodule

// File: tb/gpiot_port_tb.sv
// Scoreboard bench: driver tasks push expectations, a monitor pops and
// compares them one ns after the clock edge that follows each request.
module gpiot_port_tb;

    localparam int unsigned NP = 32;

    localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                           A_CLO = 5'h0C, A_CHI = 5'h10, A_MASK = 5'h14,
                           A_STAT = 5'h18;

    localparam int K_RD = 0, K_IRQ = 1, K_POUT = 2, K_POE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata, pad_out, pad_oe;
    logic [NP-1:0] pad_in = '0;
    logic          irq_lo, irq_hi, irq_any;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpiot_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    // Monitor: compare queued expectations after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {29'd0, irq_any, irq_hi, irq_lo};
                    K_POUT:  act = pad_out;
                    default: act = pad_oe;
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.kind = K_RD; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_out(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Stimulus: each step pushes the value the requirements predict.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        expect_read(A_DATA, 32'h0, "R1 data reset");
        expect_read(A_DIR,  32'h0, "R1 dir reset");
        expect_read(A_CLO,  32'h0, "R1 cfg lo reset");
        expect_read(A_CHI,  32'h0, "R1 cfg hi reset");
        expect_read(A_MASK, 32'h0, "R1 mask reset");
        expect_out(K_IRQ, 32'h0, "R1 irq reset");

        // Default fields are low level, pads are low: every bit pending, none enabled.
        expect_read(A_STAT, 32'hFFFF_FFFF, "R7 low level default sets all");
        expect_out(K_IRQ, 32'h0, "R10 pending but masked");

        bus_write(A_DATA, 32'hA5A5_0F0F);
        bus_write(A_DIR,  32'hFFFF_0000);
        expect_out(K_POUT, 32'hA5A5_0F0F, "R2 pad_out");
        expect_out(K_POE,  32'hFFFF_0000, "R2 pad_oe");
        expect_read(A_DATA, 32'hA5A5_0F0F, "R2 data readback");
        expect_read(A_DIR,  32'hFFFF_0000, "R2 dir readback");

        set_pads(32'h1234_5678);
        expect_read(A_PAD, 32'h1234_5678, "R3 pad sample");
        bus_write(A_PAD, 32'h0);
        expect_read(A_PAD, 32'h1234_5678, "R3 write to pad ignored");

        set_pads(32'hFFFF_FFFF);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        expect_read(A_STAT, 32'h0, "R8 clear all");

        // Low half rising, high half falling.
        bus_write(A_CLO, 32'hAAAA_AAAA);
        bus_write(A_CHI, 32'hFFFF_FFFF);
        expect_read(A_CLO, 32'hAAAA_AAAA, "R4 cfg lo readback");
        expect_read(A_CHI, 32'hFFFF_FFFF, "R4 cfg hi readback");
        expect_read(A_STAT, 32'h0, "R5 R6 no event on steady pads");

        set_pads(32'hFFEF_FFF7);
        expect_read(A_STAT, 32'h0010_0000, "R6 pin20 fall sets, R5 pin3 fall ignored");
        set_pads(32'hFFFF_FFFF);
        expect_read(A_STAT, 32'h0010_0008, "R5 pin3 rise sets, R6 pin20 rise ignored");
        expect_out(K_IRQ, 32'h0, "R10 recorded while masked");

        bus_write(A_MASK, 32'h0000_0008);
        expect_out(K_IRQ, 32'b101, "R11 low half on unmask");
        bus_write(A_MASK, 32'h0010_0008);
        expect_out(K_IRQ, 32'b111, "R11 R12 both halves");
        bus_write(A_STAT, 32'h0000_0008);
        expect_read(A_STAT, 32'h0010_0000, "R8 clear one bit only");
        expect_out(K_IRQ, 32'b110, "R11 R12 high half only");
        bus_write(A_STAT, 32'h0010_0000);
        expect_read(A_STAT, 32'h0, "R8 clear remaining");
        expect_out(K_IRQ, 32'h0, "R12 all quiet");

        // Pin 16 high level.
        bus_write(A_CHI, 32'hFFFF_FFFD);
        expect_read(A_STAT, 32'h0001_0000, "R7 R4 pin16 high level");
        expect_out(K_IRQ, 32'h0, "R11 pin16 not enabled");
        bus_write(A_STAT, 32'h0001_0000);
        expect_read(A_STAT, 32'h0001_0000, "R9 set wins over clear");
        set_pads(32'hFFFE_FFFF);
        bus_write(A_STAT, 32'h0001_0000);
        expect_read(A_STAT, 32'h0, "R8 clear after level gone");

        // Pin 0 low level.
        bus_write(A_CLO, 32'hAAAA_AAA8);
        expect_read(A_STAT, 32'h0, "R7 pin0 high input no low event");
        set_pads(32'hFFFE_FFFE);
        expect_read(A_STAT, 32'h0000_0001, "R7 pin0 low level");
        expect_out(K_IRQ, 32'h0, "R11 pin0 masked");
        bus_write(A_MASK, 32'h0000_0001);
        expect_out(K_IRQ, 32'b101, "R10 unmask pending raises at once");
        bus_write(A_STAT, 32'h0000_0001);
        expect_read(A_STAT, 32'h0000_0001, "R9 low level persists over clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule